// File: doc/BRIEF.md
# Four-Mode Serial Transceiver with Shared Pin Control

This block moves bytes over a small set of shared pins in one of four modes: a clocked link where it drives the bit clock (master), a clocked link where another device drives the bit clock (slave), and a start/stop framed link with either eight or seven data bits. A two-bit mode register picks the mode. The same register decides which of the four pads the block drives, which it only reads, and which it hands back to the general-purpose port logic.

Software-side logic writes the mode while the block is idle, sets the bit-rate divider, and pulses a start strobe with a byte. In master mode the strobe starts a transfer at once. In slave mode it arms the block and raises the ready pin. In the framed modes it sends one frame. Received bytes and completion strobes appear on the data-side outputs. The framed receiver runs on its own whenever a framed mode is selected.

Top module: `ser_mux_xcvr`

## Requirements
- R1: Mode code 2'b00 selects clocked master, 2'b01 clocked slave, 2'b10 framed 7-bit and 2'b11 framed 8-bit. `mode_o` reads 2'b00 after reset.
- R2: A mode write is dropped while `busy_o` is high. A mode write made while idle takes effect on the next clock.
- R3: Pad indices are 0 = data in, 1 = data out, 2 = bit clock, 3 = ready. Pad 0 is never driven and pad 1 is always driven. Pad 2 is driven in master mode and is an input in slave mode. Pad 3 is driven only in slave mode. A released pad (2 in the framed modes, 3 outside slave mode) carries `gpio_out_i`/`gpio_oe_i`, with bit 0 feeding pad 2 and bit 1 feeding pad 3.
- R4: In master mode the bit clock idles high. A transfer gives exactly 8 low pulses, each phase lasting `div_i`+1 cycles, and the clock ends high.
- R5: Clocked transfers are full duplex and LSB first. Data out changes after a falling clock edge, and data in is sampled at the rising edge. After the 8th rising edge, `rx_data_o` holds the 8 sampled bits and both done strobes pulse.
- R6: In slave mode the ready pad (active high) rises when a transfer is armed. It falls at the first falling clock edge and stays low after the byte completes until the block is armed again.
- R7: A framed transmit is one low start bit, then the 8 (or 7) data bits LSB first, then one high stop bit, each `div_i`+1 cycles long. Data out idles high whenever the block is not busy.
- R8: The framed receiver passes its input through two flip-flops, samples near mid-bit and returns 7-bit data with bit 7 cleared.
- R9: A start bit that is high again at its mid-bit sample is discarded: no done strobe follows and the receiver goes idle.
- R10: A low stop bit raises `frame_err_o` in the same cycle as `rx_done_o`. `frame_err_o` is low at every other time.
- R11: `rx_done_o` and `tx_done_o` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 2 | Mode code to write |
| div_i | input | DIV_W | Bit-rate divider: each bit or clock phase lasts div_i+1 cycles |
| tx_start_i | input | 1 | Start (master or framed) or arm (slave) strobe |
| tx_data_i | input | DATA_W | Byte to send |
| sin_i | input | 1 | Serial data in, from pad 0 |
| sclk_i | input | 1 | Bit clock in, from pad 2 (slave mode) |
| gpio_out_i | input | 2 | Port output values for released pads 2 and 3 |
| gpio_oe_i | input | 2 | Port output enables for released pads 2 and 3 |
| pad_o | output | 4 | Pad output values |
| pad_oe_o | output | 4 | Pad output enables |
| rx_data_o | output | DATA_W | Last received byte |
| rx_done_o | output | 1 | Receive complete pulse |
| tx_done_o | output | 1 | Transmit complete pulse |
| frame_err_o | output | 1 | Stop bit was low (with rx_done_o) |
| busy_o | output | 1 | Any engine active or armed |
| mode_o | output | 2 | Current mode |

## Verification
A shift register that lost or reordered bits shows up as a wrong received byte or wrong transmit bits on pad 1 within one transfer. The bench checks these in loopback for every mode. A wrong bit or edge counter changes the number or width of clock pulses on pad 2, or the position of the stop bit, and this is visible before the done strobe. Wrong mode or idle state shows at once on the pad enables, on the idle levels of pads 1 to 3, or as a mode write that takes effect during a transfer.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [1:0] {
    MODE_MST = 2'b00,
    MODE_SLV = 2'b01,
    MODE_A7  = 2'b10,
    MODE_A8  = 2'b11
  } ser_mode_e;

  localparam int unsigned NPADS    = 4;
  localparam int unsigned PAD_SIN  = 0;
  localparam int unsigned PAD_SOUT = 1;
  localparam int unsigned PAD_SCLK = 2;
  localparam int unsigned PAD_RDY  = 3;
endpackage

// File: rtl/ser_sync2.sv
module ser_sync2 #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ser_sync_eng.sv
// Clocked shift engine shared by master and slave: edge events come from the
// local divider (master) or from the synchronized pad clock (slave).
module ser_sync_eng #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              master_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              sclk_i,
  input  logic              sin_i,
  output logic              sout_o,
  output logic              sclk_o,
  output logic              rdy_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int unsigned NEDGE = 2 * DATA_W;
  localparam int unsigned EW    = $clog2(NEDGE);
  localparam logic [EW-1:0] LAST_EDGE = EW'(NEDGE - 1);

  logic              active_q, armed_q, sclk_q, ext_d_q, done_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [EW-1:0]     edge_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic              tick, fall_ev, rise_ev;

  assign tick    = master_i && active_q && (cnt_q == div_i);
  assign fall_ev = master_i ? (tick && sclk_q)
                            : (ext_d_q && !sclk_i && (armed_q || active_q));
  assign rise_ev = master_i ? (tick && !sclk_q)
                            : (!ext_d_q && sclk_i && active_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      armed_q  <= 1'b0;
      sclk_q   <= 1'b1;
      ext_d_q  <= 1'b1;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      edge_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q  <= 1'b0;
      ext_d_q <= sclk_i;
      if (!en_i) begin
        active_q <= 1'b0;
        armed_q  <= 1'b0;
        sclk_q   <= 1'b1;
      end else if (start_i && !active_q && !armed_q) begin
        tx_q     <= data_i;
        edge_q   <= '0;
        cnt_q    <= '0;
        sclk_q   <= 1'b1;
        active_q <= master_i;
        armed_q  <= !master_i;
      end else begin
        if (master_i && active_q) cnt_q <= tick ? '0 : cnt_q + 1'b1;
        if (tick) sclk_q <= !sclk_q;
        if (fall_ev) begin
          armed_q  <= 1'b0;
          active_q <= 1'b1;
          if (edge_q != '0) tx_q <= tx_q >> 1;
          edge_q <= edge_q + 1'b1;
        end
        if (rise_ev) begin
          rx_q   <= {sin_i, rx_q[DATA_W-1:1]};
          edge_q <= edge_q + 1'b1;
          if (edge_q == LAST_EDGE) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign sout_o = (active_q || armed_q) ? tx_q[0] : 1'b1;
  assign sclk_o = sclk_q;
  assign rdy_o  = armed_q;
  assign busy_o = active_q || armed_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/ser_async_tx.sv
module ser_async_tx #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bits8_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              sout_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned FW = DATA_W + 2;
  localparam int unsigned BW = $clog2(FW);
  localparam logic [BW-1:0] LAST8 = BW'(FW - 1);
  localparam logic [BW-1:0] LAST7 = BW'(FW - 2);

  logic             active_q, done_q;
  logic [FW-1:0]    sh_q;
  logic [BW-1:0]    bit_q;
  logic [DIV_W-1:0] cnt_q;
  logic             tick;
  logic [BW-1:0]    last_bit;

  assign tick     = active_q && (cnt_q == div_i);
  assign last_bit = bits8_i ? LAST8 : LAST7;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      sh_q     <= '1;
      bit_q    <= '0;
      cnt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        active_q <= 1'b0;
      end else if (start_i && !active_q) begin
        active_q <= 1'b1;
        bit_q    <= '0;
        cnt_q    <= '0;
        // stop bit sits above the data; in 7-bit frames an idle 1 pads the top
        sh_q <= bits8_i ? {1'b1, data_i, 1'b0}
                        : {2'b11, data_i[DATA_W-2:0], 1'b0};
      end else if (active_q) begin
        cnt_q <= tick ? '0 : cnt_q + 1'b1;
        if (tick) begin
          if (bit_q == last_bit) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            sh_q  <= {1'b1, sh_q[FW-1:1]};
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  assign sout_o = active_q ? sh_q[0] : 1'b1;
  assign busy_o = active_q;
  assign done_o = done_q;
endmodule

// File: rtl/ser_async_rx.sv
module ser_async_rx #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bits8_i,
  input  logic              sin_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o,
  output logic              ferr_o,
  output logic              busy_o
);
  localparam int unsigned BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST8 = BW'(DATA_W - 1);
  localparam logic [BW-1:0] LAST7 = BW'(DATA_W - 2);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

  rx_st_e            st_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] sh_q, data_q;
  logic              done_q, ferr_q;
  logic              full_bit;

  assign full_bit = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      data_q <= '0;
      done_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ferr_q <= 1'b0;
      cnt_q  <= cnt_q + 1'b1;
      if (!en_i) begin
        st_q <= RX_IDLE;
      end else begin
        unique case (st_q)
          RX_IDLE: begin
            cnt_q <= '0;
            if (!sin_i) st_q <= RX_START;
          end
          RX_START: if (cnt_q == (div_i >> 1)) begin
            cnt_q <= '0;
            bit_q <= '0;
            st_q  <= sin_i ? RX_IDLE : RX_DATA;  // start must still be low
          end
          RX_DATA: if (full_bit) begin
            cnt_q <= '0;
            sh_q  <= {sin_i, sh_q[DATA_W-1:1]};
            bit_q <= bit_q + 1'b1;
            if (bit_q == (bits8_i ? LAST8 : LAST7)) st_q <= RX_STOP;
          end
          RX_STOP: if (full_bit) begin
            done_q <= 1'b1;
            ferr_q <= !sin_i;
            data_q <= bits8_i ? sh_q : {1'b0, sh_q[DATA_W-1:1]};
            st_q   <= RX_IDLE;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign data_o = data_q;
  assign done_o = done_q;
  assign ferr_o = ferr_q;
  assign busy_o = (st_q != RX_IDLE);
endmodule

// File: rtl/ser_pin_mux.sv
module ser_pin_mux
  import ser_pkg::*;
(
  input  ser_mode_e        mode_i,
  input  logic             sout_i,
  input  logic             sclk_i,
  input  logic             rdy_i,
  input  logic [1:0]       gpio_out_i,
  input  logic [1:0]       gpio_oe_i,
  output logic [NPADS-1:0] pad_o,
  output logic [NPADS-1:0] pad_oe_o
);
  always_comb begin
    pad_o              = '0;
    pad_oe_o           = '0;
    pad_o[PAD_SOUT]    = sout_i;
    pad_oe_o[PAD_SOUT] = 1'b1;
    pad_o[PAD_SCLK]    = gpio_out_i[0];
    pad_oe_o[PAD_SCLK] = gpio_oe_i[0];
    pad_o[PAD_RDY]     = gpio_out_i[1];
    pad_oe_o[PAD_RDY]  = gpio_oe_i[1];
    unique case (mode_i)
      MODE_MST: begin
        pad_o[PAD_SCLK]    = sclk_i;
        pad_oe_o[PAD_SCLK] = 1'b1;
      end
      MODE_SLV: begin
        pad_o[PAD_SCLK]    = 1'b0;
        pad_oe_o[PAD_SCLK] = 1'b0;
        pad_o[PAD_RDY]     = rdy_i;
        pad_oe_o[PAD_RDY]  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ser_mux_xcvr.sv
module ser_mux_xcvr
  import ser_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wr_i,
  input  logic [1:0]        mode_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              tx_start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              sin_i,
  input  logic              sclk_i,
  input  logic [1:0]        gpio_out_i,
  input  logic [1:0]        gpio_oe_i,
  output logic [3:0]        pad_o,
  output logic [3:0]        pad_oe_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_done_o,
  output logic              tx_done_o,
  output logic              frame_err_o,
  output logic              busy_o,
  output logic [1:0]        mode_o
);
  ser_mode_e         mode_q;
  logic              is_async, is_mst, bits8;
  logic              sin_s, sclk_s;
  logic              s_sout, s_sclk, s_rdy, s_busy, s_done;
  logic [DATA_W-1:0] s_rx, a_rx;
  logic              t_sout, t_busy, t_done;
  logic              r_done, r_ferr, r_busy;
  logic              sout;

  assign is_async = mode_q[1];
  assign is_mst   = (mode_q == MODE_MST);
  assign bits8    = (mode_q == MODE_A8);
  assign busy_o   = s_busy || t_busy || r_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   mode_q <= MODE_MST;
    else if (mode_wr_i && !busy_o) mode_q <= ser_mode_e'(mode_i);
  end

  ser_sync2 #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i, .rst_ni, .d_i({sclk_i, sin_i}), .q_o({sclk_s, sin_s})
  );

  ser_sync_eng #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_sync_eng (
    .clk_i, .rst_ni,
    .en_i(!is_async), .master_i(is_mst), .start_i(tx_start_i && !is_async),
    .data_i(tx_data_i), .div_i, .sclk_i(sclk_s), .sin_i(sin_s),
    .sout_o(s_sout), .sclk_o(s_sclk), .rdy_o(s_rdy), .busy_o(s_busy),
    .done_o(s_done), .rx_o(s_rx)
  );

  ser_async_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_atx (
    .clk_i, .rst_ni,
    .en_i(is_async), .bits8_i(bits8), .start_i(tx_start_i && is_async),
    .data_i(tx_data_i), .div_i,
    .sout_o(t_sout), .busy_o(t_busy), .done_o(t_done)
  );

  ser_async_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_arx (
    .clk_i, .rst_ni,
    .en_i(is_async), .bits8_i(bits8), .sin_i(sin_s), .div_i,
    .data_o(a_rx), .done_o(r_done), .ferr_o(r_ferr), .busy_o(r_busy)
  );

  assign sout = is_async ? t_sout : s_sout;

  ser_pin_mux u_mux (
    .mode_i(mode_q), .sout_i(sout), .sclk_i(s_sclk), .rdy_i(s_rdy),
    .gpio_out_i, .gpio_oe_i, .pad_o, .pad_oe_o
  );

  assign rx_data_o   = is_async ? a_rx : s_rx;
  assign rx_done_o   = s_done || r_done;
  assign tx_done_o   = s_done || t_done;
  assign frame_err_o = r_ferr;
  assign mode_o      = mode_q;
endmodule

// File: rtl/ser_mux_xcvr_chk.sv
module ser_mux_xcvr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode_wr_i,
  input logic [1:0] mode_o,
  input logic       busy_o,
  input logic [3:0] pad_o,
  input logic [3:0] pad_oe_o,
  input logic [1:0] gpio_out_i,
  input logic [1:0] gpio_oe_i,
  input logic       rx_done_o,
  input logic       tx_done_o,
  input logic       frame_err_o
);
  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && busy_o |=> $stable(mode_o));

  p_slave_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b01 |-> !pad_oe_o[2] && pad_oe_o[3]);

  p_master_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b00 |-> pad_oe_o[2] && pad_oe_o[3] == gpio_oe_i[1] && pad_o[3] == gpio_out_i[1]);

  p_async_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[1] |-> pad_o[3:2] == gpio_out_i && pad_oe_o[3:2] == gpio_oe_i);

  p_sclk_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b00 && !busy_o |-> pad_o[2]);

  p_rdy_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b01 && !busy_o |-> !pad_o[3]);

  p_sout_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> pad_o[1]);

  p_ferr_with_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> rx_done_o);

  p_rx_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o);

  p_tx_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !tx_done_o);
endmodule

bind ser_mux_xcvr ser_mux_xcvr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_wr_i(mode_wr_i), .mode_o(mode_o),
  .busy_o(busy_o), .pad_o(pad_o), .pad_oe_o(pad_oe_o),
  .gpio_out_i(gpio_out_i), .gpio_oe_i(gpio_oe_i),
  .rx_done_o(rx_done_o), .tx_done_o(tx_done_o), .frame_err_o(frame_err_o)
);

// File: tb/sim_ser_mux_xcvr.sv
`timescale 1ns/1ps
module sim_ser_mux_xcvr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 1'b0;
  logic [1:0] mode_in = 2'b00;
  logic [7:0] div = 8'd3;
  logic       tx_start = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       sin_drv = 1'b1, sclk_drv = 1'b1, loop_en = 1'b0;
  logic [1:0] gpio_out = 2'b10, gpio_oe = 2'b00;
  logic [3:0] pad_o, pad_oe_o;
  logic [7:0] rx_data;
  logic       rx_done, tx_done, frame_err, busy;
  logic [1:0] mode_o;
  logic       sin_w;

  int n_cmp = 0, n_bad = 0, seen = 0;
  logic [7:0] cap_data;
  logic       cap_ferr;

  always #2.5 clk = ~clk;
  assign sin_w = loop_en ? pad_o[1] : sin_drv;

  ser_mux_xcvr u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .mode_i(mode_in),
    .div_i(div), .tx_start_i(tx_start), .tx_data_i(tx_data),
    .sin_i(sin_w), .sclk_i(sclk_drv), .gpio_out_i(gpio_out), .gpio_oe_i(gpio_oe),
    .pad_o(pad_o), .pad_oe_o(pad_oe_o), .rx_data_o(rx_data), .rx_done_o(rx_done),
    .tx_done_o(tx_done), .frame_err_o(frame_err), .busy_o(busy), .mode_o(mode_o)
  );

  // {mode, div, data}
  localparam logic [17:0] VEC [6] = '{
    {2'b00, 8'd3,  8'hA5},
    {2'b00, 8'd5,  8'h3C},
    {2'b11, 8'd9,  8'h5A},
    {2'b11, 8'd7,  8'hC3},
    {2'b10, 8'd9,  8'hD3},
    {2'b10, 8'd11, 8'h80}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rx_done) begin
      seen++;
      cap_data = rx_data;
      cap_ferr = frame_err;
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_in = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic pulse_start(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stopv);
    sin_drv = 1'b0; repeat (10) step();
    for (int k = 0; k < 8; k++) begin
      sin_drv = d[k]; repeat (10) step();
    end
    sin_drv = stopv; repeat (10) step();
    sin_drv = 1'b1; repeat (20) step();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [1:0] vm;
    logic [7:0] vd, got, exp_rx;
    logic [9:0] frame;
    logic [7:0] sbits;
    int falls, lows;
    logic prev;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R1 reset mode", mode_o, 2'b00);
    chk("R3 reset oe", pad_oe_o, 4'b0110);
    chk("R4 idle sclk/ready pads", pad_o[3:2], 2'b11);
    chk("R7 idle sout", pad_o[1], 1'b1);

    // pad directions per mode
    set_mode(2'b01);
    chk("R1 slave code", mode_o, 2'b01);
    chk("R3 slave oe", pad_oe_o, 4'b1010);
    chk("R6 ready idle low", pad_o[3], 1'b0);
    set_mode(2'b11);
    chk("R1 async8 code", mode_o, 2'b11);
    chk("R3 async oe", pad_oe_o, 4'b0010);
    chk("R3 async released values", pad_o[3:2], 2'b10);

    // loopback vectors
    for (int i = 0; i < 6; i++) begin
      vm = VEC[i][17:16]; div = VEC[i][15:8]; vd = VEC[i][7:0];
      exp_rx = (vm == 2'b10) ? {1'b0, vd[6:0]} : vd;
      set_mode(vm);
      loop_en = 1'b1;
      pulse_start(vd);
      falls = 0; lows = 0; seen = 0; got = 8'h00; prev = pad_o[2];
      for (int c = 0; c < 3000 && seen == 0; c++) begin
        @(negedge clk);
        if (vm == 2'b00) begin
          if (prev && !pad_o[2]) falls++;
          if (!pad_o[2]) lows++;
          prev = pad_o[2];
        end
        if (rx_done) begin seen = 1; got = rx_data; end
      end
      @(negedge clk);
      chk("R11 rx_done one cycle", rx_done, 1'b0);
      chk(vm[1] ? "R8 framed loopback data" : "R5 clocked loopback data", got, exp_rx);
      if (vm == 2'b00) begin
        chk("R4 clock pulse count", falls, 8);
        chk("R4 clock low time", lows, 8 * (div + 1));
      end
      while (busy) @(negedge clk);
    end
    loop_en = 1'b0; sin_drv = 1'b1;

    // mode write while busy
    set_mode(2'b11);
    div = 8'd9;
    pulse_start(8'h00);
    set_mode(2'b00);
    chk("R2 write dropped while busy", mode_o, 2'b11);
    while (busy) @(negedge clk);
    set_mode(2'b11);

    // framed transmit bit pattern
    pulse_start(8'h4B);
    repeat (4) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      frame[k] = pad_o[1];
      repeat (10) @(negedge clk);
    end
    chk("R7 frame bits", frame, {1'b1, 8'h4B, 1'b0});
    while (busy) @(negedge clk);
    set_mode(2'b00);
    chk("R2 write accepted when idle", mode_o, 2'b00);
    set_mode(2'b11);

    // false start
    seen = 0;
    sin_drv = 1'b0; step(); step();
    sin_drv = 1'b1;
    repeat (150) step();
    chk("R9 glitch no rx_done", seen, 0);
    chk("R9 receiver idle", busy, 1'b0);

    // good and bad stop bits
    seen = 0; cap_ferr = 1'b1;
    send_frame(8'h96, 1'b1);
    chk("R10 good frame done", seen, 1);
    chk("R8 good frame data", cap_data, 8'h96);
    chk("R10 good frame no error", cap_ferr, 1'b0);
    seen = 0; cap_ferr = 1'b0;
    send_frame(8'h69, 1'b0);
    chk("R10 bad frame done", seen, 1);
    chk("R10 bad frame error", cap_ferr, 1'b1);
    chk("R9 no restart after bad stop", busy, 1'b0);

    // slave transfer
    set_mode(2'b01);
    sclk_drv = 1'b1;
    pulse_start(8'hA5);
    chk("R6 ready after arm", pad_o[3], 1'b1);
    seen = 0; sbits = 8'h00;
    for (int b = 0; b < 8; b++) begin
      sclk_drv = 1'b0; sin_drv = vd_bit(8'h3C, b);
      repeat (6) step();
      if (b == 0) chk("R6 ready drops on first edge", pad_o[3], 1'b0);
      sbits[b] = pad_o[1];
      sclk_drv = 1'b1;
      repeat (6) step();
    end
    repeat (4) step();
    chk("R5 slave done", seen, 1);
    chk("R5 slave rx data", cap_data, 8'h3C);
    chk("R5 slave tx bits", sbits, 8'hA5);
    chk("R6 ready stays low", pad_o[3], 1'b0);

    summary();
    $finish;
  end

  function automatic logic vd_bit(input logic [7:0] d, input int idx);
    return d[idx];
  endfunction
endmodule